// File: doc/BRIEF.md
# Configurable DSSS Chip Spreader

The block spreads a serial data stream into a stream of chips. A 64-bit code register holds a pseudo-noise code. For every data symbol the block sends either the whole code or one 32-chip half of it, as stored or inverted. A small control register selects the chips per symbol (64 or 32) and the number of data bits per symbol (one or two). Data arrive as bytes over a valid/ready handshake. A last-byte marker and a bit count mark the end of a frame, and the last byte may be partial. Chips leave one at a time, paced by an external chip-enable strobe, with a flag on the first chip of each symbol.

In two-bits-per-symbol mode, the 64-bit code is used as two 32-chip halves. The first bit of each pair picks the half and the second bit picks the polarity. This doubles the raw bit rate of the 32-chip single-bit mode. The control register refuses illegal combinations and flags them. A frame that ends with a lone bit in two-bit mode drops that bit and reports it.

Top module: `dsss_spreader`

## Requirements
- R1: After reset the control readback is 0x00, the error flag is 0, `in_ready` is 1 and no chip is emitted.
- R2: Control bit 2 selects 32 chips per symbol when 1 (64 when 0), bit 1 selects two data bits per symbol when 1, and bit 0 selects fine sampling. Bits 7:3 always read back as zero.
- R3: A write whose low three bits are 3'b001, 3'b010 or 3'b011 sets the error flag and leaves the previous setting in place. A legal write stores the setting and clears the flag.
- R4: A chip appears on `chip_out` with `chip_vld` high exactly one cycle after a clock edge at which `chip_en` was high and a symbol was in progress. There is at most one chip per strobe and none without a strobe.
- R5: In 64-chip mode each data bit sends code bits 63 down to 0 in that order: as stored for a 1 and inverted for a 0.
- R6: In 32-chip single-bit mode each bit sends one half, MSB first. With `code_sel` = 0 the half is bits 31:0 and with `code_sel` = 1 it is bits 63:32. A 1 sends the half as stored and a 0 sends it inverted.
- R7: In two-bit mode each bit pair makes one 32-chip symbol. The first bit picks the half (0 selects bits 31:0, 1 selects bits 63:32) and the second bit picks the polarity (1 as stored, 0 inverted). `code_sel` has no effect in this mode.
- R8: `sym_start` is high on the first chip of every symbol and on no other chip.
- R9: Bits in a byte are taken MSB first. On the last byte (`in_last` = 1), `in_nbits` (1..8) gives the number of valid bits, held in the top positions. A full frame byte carries 8 bits.
- R10: In two-bit mode, a lone bit left at the end of a frame is not transmitted, `odd_drop` pulses for one cycle, and the block returns to accepting data.
- R11: A byte is taken only on an edge with `in_valid` and `in_ready` both high. `in_ready` stays low until every bit of the held byte is consumed.
- R12: The sampling bit does not change the chip stream: setting 3'b101 produces the same chips as 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Control readback |
| cfg_err | output | 1 | Illegal setting written |
| code_wr | input | 1 | Code register write strobe |
| code_wdata | input | 64 | Code value |
| code_sel | input | 1 | Half select for 32-chip single-bit mode |
| in_data | input | 8 | Data byte |
| in_valid | input | 1 | Data byte valid |
| in_last | input | 1 | Byte ends the frame |
| in_nbits | input | 4 | Valid bits in the last byte (1..8) |
| in_ready | output | 1 | Block can take a byte |
| chip_en | input | 1 | Chip pacing strobe |
| chip_out | output | 1 | Chip value |
| chip_vld | output | 1 | Chip emitted this cycle |
| sym_start | output | 1 | First chip of a symbol |
| odd_drop | output | 1 | Lone bit dropped in two-bit mode |

## Verification
Control writes take effect at the next edge, so readback and the error flag are checked one cycle after the write strobe. A chip is due one cycle after the strobe edge that produces it. The bench samples on the falling edge and tests every `chip_vld` against the strobe level it held through the previous rising edge. There may be a gap of one cycle between symbols, so each frame's chips are gathered in order and compared with a stream the bench computes from the code, the mode and the frame bits. The drop pulse is counted over the whole frame window.

// File: rtl/dsss_pkg.sv
// Package: shared mode type and legality rule for the chip spreader.
// Assumes the control field occupies the low three bits of the register.
package dsss_pkg;

    localparam int MODE_W = 3;

    typedef struct packed {
        logic width32;   // 1: 32 chips per symbol, 0: 64
        logic dbl;       // 1: two data bits per symbol
        logic fine;      // sampling choice, no effect on chips
    } mode_t;

    // A 64-chip setting must have both lower bits clear.
    function automatic logic mode_legal(input logic [MODE_W-1:0] f);
        return f[2] || (f[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/dsss_ctrl_reg.sv
// Control register: stores the mode field, rejects illegal settings and
// raises an error flag for them. Assumes CTRL_W >= MODE_W.
module dsss_ctrl_reg
    import dsss_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic              err,
    output mode_t             mode
);

    localparam int PAD_W = CTRL_W - MODE_W;

    logic [MODE_W-1:0] field;

    // Capture legal settings, flag illegal ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= '0;
            err   <= 1'b0;
        end else if (wr) begin
            if (mode_legal(wdata[MODE_W-1:0])) begin
                field <= wdata[MODE_W-1:0];
                err   <= 1'b0;
            end else begin
                err   <= 1'b1;
            end
        end
    end

    // Readback with reserved bits forced low; decoded mode.
    always_comb begin
        rdata = {{PAD_W{1'b0}}, field};
        mode  = mode_t'(field);
    end

    // R3: an illegal write keeps the setting and raises the flag
    a_r3_bad_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mode_legal(wdata[MODE_W-1:0])) |=> (err && field == $past(field)));

    // R2: the stored field is always a legal combination
    a_r2_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(field));

endmodule

// File: rtl/dsss_unpack.sv
// Byte unpacker: holds one byte and hands out bits MSB first, one or two
// per request. Assumes the consumer never asks for more bits than held.
module dsss_unpack #(
    parameter int BYTE_W = 8,
    parameter int NB_W   = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [NB_W-1:0]   in_nbits,
    output logic              in_ready,
    input  logic              take1,
    input  logic              take2,
    output logic [NB_W-1:0]   avail,
    output logic [1:0]        head2,
    output logic              is_last
);

    localparam logic [NB_W-1:0] FULL = NB_W'(BYTE_W);

    logic [BYTE_W-1:0] sh;
    logic [NB_W-1:0]   cnt;
    logic              lst;
    logic [NB_W-1:0]   load_cnt;

    // Bit count for an incoming byte; out-of-range counts mean a full byte.
    always_comb begin
        if (in_last && in_nbits != '0 && in_nbits <= FULL)
            load_cnt = in_nbits;
        else
            load_cnt = FULL;
    end

    // Load a byte when empty, otherwise shift out consumed bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
            lst <= 1'b0;
        end else if (in_valid && in_ready) begin
            sh  <= in_data;
            cnt <= load_cnt;
            lst <= in_last;
        end else if (take2) begin
            sh  <= {sh[BYTE_W-3:0], 2'b00};
            cnt <= cnt - NB_W'(2);
        end else if (take1) begin
            sh  <= {sh[BYTE_W-2:0], 1'b0};
            cnt <= cnt - NB_W'(1);
        end
    end

    // Status towards the producer and the symbol engine.
    always_comb begin
        in_ready = (cnt == '0);
        avail    = cnt;
        head2    = sh[BYTE_W-1:BYTE_W-2];
        is_last  = lst;
    end

    // R11: a taken byte always leaves bits to consume
    a_r11_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (cnt != '0));

    // R11: the engine never draws more bits than are held
    a_r11_no_overdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (take2 |-> cnt >= NB_W'(2)) and (take1 |-> cnt != '0));

endmodule

// File: rtl/dsss_chip_gen.sv
// Symbol engine: picks the code segment and polarity for the next symbol
// from the data bits and mode, then shifts chips out MSB first, one per
// chip strobe. Assumes CODE_W is even; the mode is read at each symbol load.
module dsss_chip_gen
    import dsss_pkg::*;
#(
    parameter int CODE_W = 64,
    parameter int NB_W   = 4,
    parameter int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode,
    input  logic [CODE_W-1:0] code,
    input  logic              code_sel,
    input  logic              chip_en,
    input  logic [NB_W-1:0]   avail,
    input  logic [1:0]        head2,
    input  logic              is_last,
    output logic              take1,
    output logic              take2,
    output logic              chip_out,
    output logic              chip_vld,
    output logic              sym_start,
    output logic              odd_drop
);

    localparam int HALF = CODE_W / 2;

    logic [CODE_W-1:0] sym_sh;
    logic [CNT_W-1:0]  left;
    logic              inv;
    logic              first;

    logic              idle, pair_mode, load, drop;
    logic [HALF-1:0]   lo, hi, half_pick;
    logic [CODE_W-1:0] seg;
    logic              seg_inv;
    logic [CNT_W-1:0]  seg_len;

    // Decide whether to start a symbol, drop a lone bit, or wait.
    always_comb begin
        idle      = (left == '0);
        pair_mode = mode.width32 & mode.dbl;
        take1     = 1'b0;
        take2     = 1'b0;
        load      = 1'b0;
        drop      = 1'b0;
        if (idle && avail != '0) begin
            if (pair_mode) begin
                if (avail >= NB_W'(2)) begin
                    take2 = 1'b1;
                    load  = 1'b1;
                end else if (is_last) begin
                    take1 = 1'b1;
                    drop  = 1'b1;
                end
            end else begin
                take1 = 1'b1;
                load  = 1'b1;
            end
        end
    end

    // Build the left-aligned segment, its length and polarity.
    always_comb begin
        lo        = code[HALF-1:0];
        hi        = code[CODE_W-1:HALF];
        half_pick = lo;
        if (!mode.width32) begin
            seg     = code;
            seg_len = CNT_W'(CODE_W);
            seg_inv = ~head2[1];
        end else if (pair_mode) begin
            half_pick = head2[1] ? hi : lo;
            seg       = {half_pick, {HALF{1'b0}}};
            seg_len   = CNT_W'(HALF);
            seg_inv   = ~head2[0];
        end else begin
            half_pick = code_sel ? hi : lo;
            seg       = {half_pick, {HALF{1'b0}}};
            seg_len   = CNT_W'(HALF);
            seg_inv   = ~head2[1];
        end
    end

    // Load a symbol when idle, otherwise emit one chip per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_sh    <= '0;
            left      <= '0;
            inv       <= 1'b0;
            first     <= 1'b0;
            chip_out  <= 1'b0;
            chip_vld  <= 1'b0;
            sym_start <= 1'b0;
            odd_drop  <= 1'b0;
        end else begin
            chip_vld  <= 1'b0;
            sym_start <= 1'b0;
            odd_drop  <= drop;
            if (load) begin
                sym_sh <= seg;
                left   <= seg_len;
                inv    <= seg_inv;
                first  <= 1'b1;
            end else if (!idle && chip_en) begin
                chip_out  <= sym_sh[CODE_W-1] ^ inv;
                chip_vld  <= 1'b1;
                sym_start <= first;
                first     <= 1'b0;
                sym_sh    <= {sym_sh[CODE_W-2:0], 1'b0};
                left      <= left - CNT_W'(1);
            end
        end
    end

    // R4: every chip follows a strobe on the previous edge
    a_r4_chip_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        chip_vld |-> $past(chip_en));

    // R8: the symbol flag only rides on an emitted chip
    a_r8_start_on_chip: assert property (@(posedge clk) disable iff (!rst_n)
        sym_start |-> chip_vld);

    // R10: lone bits are only dropped in two-bit mode
    a_r10_drop_in_pair_mode: assert property (@(posedge clk) disable iff (!rst_n)
        odd_drop |-> $past(pair_mode));

endmodule

// File: rtl/dsss_spreader.sv
// Top of the chip spreader: control register, code register, byte
// unpacker and symbol engine. Assumes the mode and code are changed only
// between frames; the code is copied into the engine at each symbol load.
module dsss_spreader
    import dsss_pkg::*;
#(
    parameter int CODE_W = 64,
    parameter int BYTE_W = 8,
    parameter int CTRL_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr,
    input  logic [CTRL_W-1:0]            cfg_wdata,
    output logic [CTRL_W-1:0]            cfg_rdata,
    output logic                         cfg_err,
    input  logic                         code_wr,
    input  logic [CODE_W-1:0]            code_wdata,
    input  logic                         code_sel,
    input  logic [BYTE_W-1:0]            in_data,
    input  logic                         in_valid,
    input  logic                         in_last,
    input  logic [$clog2(BYTE_W+1)-1:0]  in_nbits,
    output logic                         in_ready,
    input  logic                         chip_en,
    output logic                         chip_out,
    output logic                         chip_vld,
    output logic                         sym_start,
    output logic                         odd_drop
);

    localparam int NB_W = $clog2(BYTE_W + 1);

    mode_t             mode;
    logic [CODE_W-1:0] code_q;
    logic              take1, take2, is_last;
    logic [NB_W-1:0]   avail;
    logic [1:0]        head2;

    // Code register, written as a whole.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (code_wr)
            code_q <= code_wdata;
    end

    dsss_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .err   (cfg_err),
        .mode  (mode)
    );

    dsss_unpack #(.BYTE_W(BYTE_W), .NB_W(NB_W)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_nbits (in_nbits),
        .in_ready (in_ready),
        .take1    (take1),
        .take2    (take2),
        .avail    (avail),
        .head2    (head2),
        .is_last  (is_last)
    );

    dsss_chip_gen #(.CODE_W(CODE_W), .NB_W(NB_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .code      (code_q),
        .code_sel  (code_sel),
        .chip_en   (chip_en),
        .avail     (avail),
        .head2     (head2),
        .is_last   (is_last),
        .take1     (take1),
        .take2     (take2),
        .chip_out  (chip_out),
        .chip_vld  (chip_vld),
        .sym_start (sym_start),
        .odd_drop  (odd_drop)
    );

endmodule

// File: tb/dsss_spreader_tb.sv
`timescale 1ns/1ps
module dsss_spreader_tb;

    localparam int  MAXC = 4096;
    localparam logic [63:0] CODE = 64'h9E37_79B9_7F4A_7C15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cfg_err;
    logic        code_wr = 1'b0;
    logic [63:0] code_wdata = '0;
    logic        code_sel = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [3:0]  in_nbits = '0;
    logic        in_ready;
    logic        chip_en = 1'b0;
    logic        chip_out, chip_vld, sym_start, odd_drop;

    int n_checks = 0;
    int n_errors = 0;

    int n_got = 0, n_drop = 0, r4_bad = 0, en_ctr = 0, en_div = 1;
    bit got_c [MAXC];
    bit got_s [MAXC];
    bit exp_c [MAXC];
    bit exp_s [MAXC];
    int exp_n, exp_drop;
    logic [7:0] fb [4];
    logic [2:0] cur_mode;

    always #4 clk = ~clk;

    dsss_spreader u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .code_wr(code_wr),
        .code_wdata(code_wdata), .code_sel(code_sel), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_nbits(in_nbits),
        .in_ready(in_ready), .chip_en(chip_en), .chip_out(chip_out),
        .chip_vld(chip_vld), .sym_start(sym_start), .odd_drop(odd_drop)
    );

    // Collect chips, check strobe pacing (R4), then drive the next strobe.
    always @(negedge clk) begin
        if (chip_vld) begin
            if (!chip_en) r4_bad++;
            if (n_got < MAXC) begin
                got_c[n_got] = chip_out;
                got_s[n_got] = sym_start;
            end
            n_got++;
        end
        if (odd_drop) n_drop++;
        en_ctr++;
        chip_en = rst_n && ((en_ctr % en_div) == 0);
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Expected chips for one symbol from a segment of len chips.
    task automatic push_sym(input logic [63:0] seg, input int len, input bit true_pol);
        for (int c = len - 1; c >= 0; c--) begin
            exp_c[exp_n] = true_pol ? seg[c] : ~seg[c];
            exp_s[exp_n] = (c == len - 1);
            exp_n++;
        end
    endtask

    task automatic run_frame(input int nbytes, input int lastbits, input string tag);
        bit bits [32];
        int nb = 0, w = 0, bad_c = 0, bad_s = 0, i;
        for (int b = 0; b < nbytes; b++) begin
            int k = (b == nbytes - 1) ? lastbits : 8;
            for (int j = 0; j < k; j++) begin
                bits[nb] = fb[b][7 - j];
                nb++;
            end
        end
        exp_n = 0; exp_drop = 0;
        if (!cur_mode[2]) begin
            for (int j = 0; j < nb; j++) push_sym(CODE, 64, bits[j]);
        end else if (cur_mode[1]) begin
            i = 0;
            while (i + 1 < nb) begin
                push_sym({32'h0, bits[i] ? CODE[63:32] : CODE[31:0]}, 32, bits[i+1]);
                i += 2;
            end
            if (i < nb) exp_drop = 1;
        end else begin
            for (int j = 0; j < nb; j++)
                push_sym({32'h0, code_sel ? CODE[63:32] : CODE[31:0]}, 32, bits[j]);
        end
        n_got = 0; n_drop = 0; r4_bad = 0;
        for (int b = 0; b < nbytes; b++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_data = fb[b];
            in_last = (b == nbytes - 1);
            in_nbits = 4'((b == nbytes - 1) ? lastbits : 8);
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            if (b == 0) check(!in_ready, "R11 ready low while byte held", int'(in_ready), 0);
        end
        while ((n_got < exp_n || n_drop < exp_drop) && w < 20000) begin
            @(negedge clk);
            w++;
        end
        repeat (8) @(negedge clk);
        check(n_got == exp_n, {tag, " chip count"}, n_got, exp_n);
        for (int j = 0; j < exp_n && j < n_got; j++) begin
            if (got_c[j] != exp_c[j]) bad_c++;
            if (got_s[j] != exp_s[j]) bad_s++;
        end
        check(bad_c == 0, {tag, " R9 chip values"}, bad_c, 0);
        check(bad_s == 0, "R8 symbol flags", bad_s, 0);
        check(n_drop == exp_drop, "R10 drop pulses", n_drop, exp_drop);
        check(r4_bad == 0, "R4 chip without strobe", r4_bad, 0);
        check(in_ready == 1'b1, "R10 ready after frame", int'(in_ready), 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (195000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int modes [5] = '{0, 4, 5, 6, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 8'h00, "R1 control reset", cfg_rdata, 0);
        check(cfg_err == 1'b0, "R1 error reset", cfg_err, 0);
        check(in_ready == 1'b1, "R1 ready reset", in_ready, 1);
        check(chip_vld == 1'b0, "R1 no chip", chip_vld, 0);

        @(negedge clk);
        code_wr = 1'b1; code_wdata = CODE;
        @(negedge clk);
        code_wr = 1'b0;

        // R2 reserved bits read zero
        cfg_write(8'hFC);
        check(cfg_rdata == 8'h04, "R2 reserved masked", cfg_rdata, 8'h04);
        check(cfg_err == 1'b0, "R2 legal write no error", cfg_err, 0);
        cfg_write(8'hFF);
        check(cfg_rdata == 8'h07, "R2 all legal bits", cfg_rdata, 8'h07);
        cfg_write(8'h04);
        // R3 illegal settings rejected
        for (int v = 1; v <= 3; v++) begin
            cfg_write(8'(v));
            check(cfg_err == 1'b1, "R3 error raised", cfg_err, 1);
            check(cfg_rdata == 8'h04, "R3 mode kept", cfg_rdata, 8'h04);
        end
        cfg_write(8'h00);
        check(cfg_err == 1'b0, "R3 error cleared", cfg_err, 0);
        check(cfg_rdata == 8'h00, "R3 legal stored", cfg_rdata, 0);

        foreach (modes[m]) begin
            string tag;
            cur_mode = 3'(modes[m]);
            cfg_write({5'b0, cur_mode});
            case (modes[m])
                0:       tag = "R5";
                4:       tag = "R6";
                5:       tag = "R12";
                default: tag = "R7";
            endcase
            for (int sel = 0; sel < 2; sel++) begin
                for (int d = 0; d < 2; d++) begin
                    en_div = (d == 0) ? 1 : 3;
                    code_sel = sel[0];
                    fb[0] = 8'h B4 + 8'(m * 37) + 8'(sel);
                    fb[1] = 8'h6D ^ 8'(m * 11 + sel * 5 + d);
                    run_frame(2, 8, tag);
                    fb[0] = 8'h3C ^ 8'(m * 29 + d);
                    fb[1] = 8'hE1 + 8'(sel * 3);
                    run_frame(2, 3, tag);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule